// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block is the write side of a parallel NOR flash model. It uses the common command set that has multi-cycle sequences. Every write on a simple synchronous bus carries an address, a data word and a size of 1, 2 or 4 bytes. The block decodes each write as a command byte or as a later phase of a sequence already in progress. It then programs bytes, erases sectors or moves between read modes. The sequences it handles are:

- word program
- sector erase
- status clear
- lock and unlock
- status, identifier and query read selection
- buffered write with count, data and confirm phases
- return to array read

The block holds a small byte array and an 8-bit status register. It reports the current read mode so that a separate read path can pick between array data, status, identifier and query data. A combinational port reads the array directly. A write-protect input blocks changes to the array and sets error bits in the status register instead.

Top module: `flash_cmd_fsm`

## Requirements
- R1: When a first-cycle command byte 0x10 or 0x40 is followed by a write, the block stores that write's data little-endian at its address. It stores 1, 2 or 4 bytes for a size code of 0, 1 or 2, and then sets status bit 7.
- R2: When a first-cycle byte 0x20 or 0x28 is followed by 0xD0, every byte of the sector holding the address (SECTOR_BYTES, aligned down) is set to 0xFF and status bit 7 is set. A second byte of 0xFF returns to array read and leaves the array unchanged.
- R3: While the protect input is high, a program leaves the array unchanged and sets status bits 4 and 7. An erase leaves the array unchanged and sets status bits 5 and 7.
- R4: The command 0x50 clears the status register to 0 and selects array read. The commands 0xFF and 0xF0 select array read.
- R5: The command 0x60 selects status read. A second byte of 0x01 or 0xD0 sets status bit 7. A second byte of 0xFF selects array read.
- R6: The read mode code is 0 for array, 1 for status, 2 for identifier and 3 for query. The commands 0x70, 0x90 and 0x98 select 1, 2 and 3. Program, erase, lock and buffered write select 1. Query mode ignores every write except 0xFF, which selects array read.
- R7: The command 0xE8 sets status bit 7 at once.
- R8: In a buffered write, the second write gives a count N, masked to the low DEV_BYTES bytes (the default is 1 byte). N+1 data writes follow, each stored as in R1. The next write must be the 0xD0 confirm, which sets status bit 7.
- R9: A byte that does not fit the current sequence step returns the block to array read, back at the first step. This covers a first-cycle byte that is not a command, and an erase, lock or confirm step that gets a byte other than those listed above.
- R10: A high synchronous reset clears the status register, selects array read and makes the next write a first-cycle command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8*BANK_BYTES | Write data; the low byte carries commands |
| wr_size | input | 2 | Write size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| wp | input | 1 | Write protect |
| rd_addr | input | ADDR_W | Byte address of the array read |
| rd_data | output | 8*BANK_BYTES | Array bytes from rd_addr upward, little-endian |
| status | output | 8 | Status register |
| rd_mode | output | 2 | Selected read mode |

## Verification
A wrong sequence step shows up on the write that follows it. Data can land in the array when it should not, or a command byte can be treated as data. The rd_mode output then keeps the wrong value, and this is visible one cycle after that write. A wrong buffered-write count shows up only when the confirm arrives. The bench therefore follows each buffer with a mode-select command: if the count is off, that command is stored as data instead of changing rd_mode. Status errors show up one cycle after the offending write, and the array read port shows whether the stored bytes stayed unchanged.

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
  parameter int ADDR_W       = 8,
  parameter int SECTOR_BYTES = 64,
  parameter int BANK_BYTES   = 4,
  parameter int DEV_BYTES    = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [8*BANK_BYTES-1:0] wr_data,
  input  logic [1:0]              wr_size,
  input  logic                    wp,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [8*BANK_BYTES-1:0] rd_data,
  output logic [7:0]              status,
  output logic [1:0]              rd_mode
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int SEC_W    = $clog2(SECTOR_BYTES);
  localparam int CNT_BITS = ((DEV_BYTES != 0) ? DEV_BYTES : BANK_BYTES) * 8;

  localparam logic [7:0] OP_PROG_A  = 8'h10;
  localparam logic [7:0] OP_PROG_B  = 8'h40;
  localparam logic [7:0] OP_ERASE_A = 8'h20;
  localparam logic [7:0] OP_ERASE_B = 8'h28;
  localparam logic [7:0] OP_CLEAR   = 8'h50;
  localparam logic [7:0] OP_LOCK    = 8'h60;
  localparam logic [7:0] OP_STAT    = 8'h70;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_QUERY   = 8'h98;
  localparam logic [7:0] OP_BUF     = 8'hE8;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_ARRAY   = 8'hFF;
  localparam logic [7:0] OP_ARRAY2  = 8'hF0;
  localparam logic [7:0] OP_LOCKBIT = 8'h01;

  logic [7:0]          mem [DEPTH];
  logic [1:0]          cyc;
  logic [7:0]          cmd;
  logic [7:0]          stat;
  logic [CNT_BITS-1:0] cnt;
  logic [2:0]          nbytes;
  logic                do_prog;
  logic                do_erase;

  wire [7:0] op      = wr_data[7:0];
  wire       is_prog  = (cmd == OP_PROG_A) || (cmd == OP_PROG_B);
  wire       is_erase = (cmd == OP_ERASE_A) || (cmd == OP_ERASE_B);

  assign status = stat;

  assign nbytes = (wr_size == 2'd0) ? 3'd1 : (wr_size == 2'd1) ? 3'd2 : 3'd4;

  assign do_prog  = wr_en && !wp && ((cyc == 2'd1 && is_prog) || cyc == 2'd2);
  assign do_erase = wr_en && !wp && cyc == 2'd1 && is_erase && op == OP_CONFIRM;

  always_comb begin
    case (cmd)
      OP_ARRAY: rd_mode = 2'd0;
      OP_IDENT: rd_mode = 2'd2;
      OP_QUERY: rd_mode = 2'd3;
      default:  rd_mode = 2'd1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (do_erase) begin
      for (int i = 0; i < DEPTH; i++)
        if ((ADDR_W'(i) >> SEC_W) == (wr_addr >> SEC_W))
          mem[i] <= 8'hFF;
    end else if (do_prog) begin
      for (int b = 0; b < BANK_BYTES; b++)
        if (3'(b) < nbytes)
          mem[wr_addr + ADDR_W'(b)] <= wr_data[8*b +: 8];
    end
  end

  for (genvar g = 0; g < BANK_BYTES; g++) begin : g_rd
    assign rd_data[8*g +: 8] = mem[rd_addr + ADDR_W'(g)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc  <= 2'd0;
      cmd  <= OP_ARRAY;
      stat <= 8'h00;
      cnt  <= '0;
    end else if (wr_en) begin
      case (cyc)
        2'd0: begin
          case (op)
            OP_PROG_A, OP_PROG_B, OP_ERASE_A, OP_ERASE_B, OP_LOCK, OP_QUERY: begin
              cmd <= op;
              cyc <= 2'd1;
            end
            OP_BUF: begin
              cmd  <= op;
              cyc  <= 2'd1;
              stat <= stat | 8'h80;
            end
            OP_CLEAR: begin
              stat <= 8'h00;
              cmd  <= OP_ARRAY;
            end
            OP_STAT, OP_IDENT: cmd <= op;
            default:           cmd <= OP_ARRAY;
          endcase
        end
        2'd1: begin
          if (is_prog) begin
            stat <= stat | 8'h80 | (wp ? 8'h10 : 8'h00);
            cyc  <= 2'd0;
          end else if (is_erase) begin
            if (op == OP_CONFIRM) stat <= stat | 8'h80 | (wp ? 8'h20 : 8'h00);
            else                  cmd  <= OP_ARRAY;
            cyc <= 2'd0;
          end else if (cmd == OP_LOCK) begin
            if (op == OP_LOCKBIT || op == OP_CONFIRM) stat <= stat | 8'h80;
            else                                      cmd  <= OP_ARRAY;
            cyc <= 2'd0;
          end else if (cmd == OP_QUERY) begin
            if (op == OP_ARRAY) begin
              cmd <= OP_ARRAY;
              cyc <= 2'd0;
            end
          end else if (cmd == OP_BUF) begin
            cnt <= wr_data[CNT_BITS-1:0];
            cyc <= 2'd2;
          end else begin
            cmd <= OP_ARRAY;
            cyc <= 2'd0;
          end
        end
        2'd2: begin
          if (wp) stat <= stat | 8'h10;
          if (cnt == '0) cyc <= 2'd3;
          else           cnt <= cnt - 1'b1;
        end
        default: begin
          if (op == OP_CONFIRM) stat <= stat | 8'h80;
          else                  cmd  <= OP_ARRAY;
          cyc <= 2'd0;
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_fsm_chk.sv
module flash_cmd_fsm_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] op,
  input logic       wp,
  input logic [7:0] status,
  input logic [1:0] rd_mode,
  input logic [1:0] cyc,
  input logic [7:0] cmd
);
  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (status == 8'h00 && rd_mode == 2'd0)); // R10

  AST_PROG_READY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cyc == 2'd1 && (cmd == 8'h10 || cmd == 8'h40)) |=> status[7]); // R1

  AST_ERR_NEEDS_WP: assert property (@(posedge clk) disable iff (rst)
    ($rose(status[4]) || $rose(status[5])) |-> $past(wp)); // R3

  AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cyc == 2'd0 && op == 8'h50) |=> (status == 8'h00 && rd_mode == 2'd0)); // R4

  AST_QUERY_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rd_mode == 2'd3 && wr_en && op != 8'hFF) |=> rd_mode == 2'd3); // R6

  AST_BUF_READY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cyc == 2'd0 && op == 8'hE8) |=> status[7]); // R7
endmodule

bind flash_cmd_fsm flash_cmd_fsm_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .op(wr_data[7:0]), .wp(wp),
  .status(status), .rd_mode(rd_mode), .cyc(cyc), .cmd(cmd)
);

// File: tb/test_flash_cmd_fsm.sv
module test_flash_cmd_fsm;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic [1:0]        wr_size = 2'd2;
  logic              wp = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [31:0]       rd_data;
  logic [7:0]        status;
  logic [1:0]        rd_mode;
  int checks = 0;
  int errors = 0;

  flash_cmd_fsm i_flash_cmd_fsm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_size(wr_size), .wp(wp), .rd_addr(rd_addr), .rd_data(rd_data),
    .status(status), .rd_mode(rd_mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] s = 2'd2);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_size = s; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset;
    chk("R10 status after reset", 32'(status), 32'h00);
    chk("R10 mode after reset", 32'(rd_mode), 32'd0);
  endtask

  task automatic t_program;
    wr(8'h10, 32'h20); wr(8'h10, 32'hD0);
    rd_chk("R2 sector0 low", 8'h00, 32'hFFFFFFFF);
    rd_chk("R2 sector0 top", 8'h3C, 32'hFFFFFFFF);
    chk("R2 erase ready", 32'(status), 32'h80);
    wr(8'h00, 32'h40); wr(8'h04, 32'h12345678, 2'd2);
    rd_chk("R1 word program", 8'h04, 32'h12345678);
    chk("R1 ready", 32'(status), 32'h80);
    chk("R6 mode status after program", 32'(rd_mode), 32'd1);
    wr(8'h00, 32'h10); wr(8'h08, 32'h9999ABCD, 2'd1);
    rd_chk("R1 half program", 8'h08, 32'hFFFFABCD);
    wr(8'h00, 32'h40); wr(8'h0C, 32'h7777775A, 2'd0);
    rd_chk("R1 byte program", 8'h0C, 32'hFFFFFF5A);
  endtask

  task automatic t_erase;
    wr(8'h00, 32'h28); wr(8'h47, 32'hD0);
    rd_chk("R2 sector1 low", 8'h40, 32'hFFFFFFFF);
    rd_chk("R2 sector1 top", 8'h7C, 32'hFFFFFFFF);
    rd_chk("R2 other sector kept", 8'h04, 32'h12345678);
    wr(8'h00, 32'h40); wr(8'h44, 32'h11223344);
    wr(8'h44, 32'h20); wr(8'h44, 32'hFF);
    chk("R2 abort mode", 32'(rd_mode), 32'd0);
    rd_chk("R2 abort keeps data", 8'h44, 32'h11223344);
    wr(8'h44, 32'h20); wr(8'h44, 32'h77);
    chk("R9 bad erase confirm mode", 32'(rd_mode), 32'd0);
    rd_chk("R9 bad erase keeps data", 8'h44, 32'h11223344);
    wr(8'h00, 32'h20); wr(8'h7F, 32'hD0);
    rd_chk("R2 aligned erase", 8'h44, 32'hFFFFFFFF);
  endtask

  task automatic t_protect;
    wr(8'h00, 32'h50);
    wp = 1'b1;
    wr(8'h00, 32'h40); wr(8'h04, 32'h00000000);
    rd_chk("R3 protected program", 8'h04, 32'h12345678);
    chk("R3 program error", 32'(status), 32'h90);
    wr(8'h00, 32'h50);
    wr(8'h00, 32'h20); wr(8'h00, 32'hD0);
    rd_chk("R3 protected erase", 8'h04, 32'h12345678);
    chk("R3 erase error", 32'(status), 32'hA0);
    wp = 1'b0;
  endtask

  task automatic t_clear;
    wr(8'h00, 32'h50);
    chk("R4 clear status", 32'(status), 32'h00);
    chk("R4 clear mode", 32'(rd_mode), 32'd0);
    wr(8'h00, 32'h70);
    chk("R6 status mode", 32'(rd_mode), 32'd1);
    wr(8'h00, 32'hF0);
    chk("R4 F0 to array", 32'(rd_mode), 32'd0);
    wr(8'h00, 32'h70); wr(8'h00, 32'hFF);
    chk("R4 FF to array", 32'(rd_mode), 32'd0);
  endtask

  task automatic t_lock;
    wr(8'h00, 32'h60);
    chk("R5 lock mode", 32'(rd_mode), 32'd1);
    wr(8'h00, 32'h01);
    chk("R5 lock ready", 32'(status), 32'h80);
    wr(8'h00, 32'h50); wr(8'h00, 32'h60); wr(8'h00, 32'hD0);
    chk("R5 unlock ready", 32'(status), 32'h80);
    wr(8'h00, 32'h50); wr(8'h00, 32'h60); wr(8'h00, 32'hFF);
    chk("R5 lock abort mode", 32'(rd_mode), 32'd0);
    chk("R5 lock abort status", 32'(status), 32'h00);
  endtask

  task automatic t_modes;
    wr(8'h00, 32'h90);
    chk("R6 ident mode", 32'(rd_mode), 32'd2);
    wr(8'h00, 32'h98);
    chk("R6 query mode", 32'(rd_mode), 32'd3);
    wr(8'h00, 32'h70);
    chk("R6 query ignores 70", 32'(rd_mode), 32'd3);
    wr(8'h00, 32'h20);
    chk("R6 query ignores 20", 32'(rd_mode), 32'd3);
    wr(8'h00, 32'hFF);
    chk("R6 query exit", 32'(rd_mode), 32'd0);
  endtask

  task automatic t_buffer;
    wr(8'h00, 32'h50);
    wr(8'h80, 32'hE8);
    chk("R7 buffer ready at once", 32'(status), 32'h80);
    wr(8'h80, 32'h103);
    wr(8'h80, 32'hA3A2A1A0);
    wr(8'h84, 32'hB3B2B1B0);
    wr(8'h88, 32'hC3C2C1C0);
    wr(8'h8C, 32'hD3D2D1D0);
    wr(8'h80, 32'hD0);
    chk("R8 confirm ready", 32'(status), 32'h80);
    wr(8'h00, 32'h90);
    chk("R8 count masked, back to commands", 32'(rd_mode), 32'd2);
    rd_chk("R8 buffer word 0", 8'h80, 32'hA3A2A1A0);
    rd_chk("R8 buffer word 3", 8'h8C, 32'hD3D2D1D0);
    wr(8'h00, 32'hE8); wr(8'h00, 32'h0); wr(8'h90, 32'hCAFEF00D); wr(8'h00, 32'h55);
    chk("R9 bad buffer confirm", 32'(rd_mode), 32'd0);
    rd_chk("R8 single word buffer", 8'h90, 32'hCAFEF00D);
    wr(8'h00, 32'h70); wr(8'h00, 32'h33);
    chk("R9 unknown command", 32'(rd_mode), 32'd0);
  endtask

  task automatic t_midreset;
    wr(8'h00, 32'h40);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R10 reset status", 32'(status), 32'h00);
    chk("R10 reset mode", 32'(rd_mode), 32'd0);
    wr(8'h04, 32'h70);
    chk("R10 next write is command", 32'(rd_mode), 32'd1);
    rd_chk("R10 no stale program", 8'h04, 32'h12345678);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_program();
    t_erase();
    t_protect();
    t_clear();
    t_lock();
    t_modes();
    t_buffer();
    t_midreset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule